// File: doc/BRIEF.md
# Hierarchy Gateway Address Rewriter

This block is the header-edit stage of a switch that sits where two levels of an address hierarchy meet. It takes the parsed fields of a compact network header and an action code from the lookup stage. It can lengthen the source address by putting this level's prefix bytes above it, which happens when a packet climbs out of a lower level. It can shorten the destination address by removing this level's prefix bytes, which happens when a packet descends into a lower level. Either way, the packet keeps only the address bytes needed to identify each end uniquely.

Each address travels right-aligned in a 128-bit vector, and its byte count is given by a 4-bit length code. After the edit, the block re-encodes both length codes, decrements the hop limit, flags expired packets for dropping, and recomputes the padded header length. All of this is done in one registered cycle, so the stage adds no latency beyond its own register.

Top module: `hier_gw_rewriter`

## Requirements
- R1: `o_vld` equals `i_vld` delayed by exactly one clock. While `o_vld` is low, `o_err` and `o_drop` are low.
- R2: A length code of 0 means 16 bytes, and codes 1 to 15 mean that many bytes. Output addresses are right-aligned, and every byte above the output length reads as zero.
- R3: When the two input length codes are equal, both addresses and both codes pass unchanged, whatever the action, and `o_err` stays low.
- R4: The action is encoded as 0 = pass, 1 = lengthen source, 2 = shorten destination. Code 3 is reserved and behaves as pass.
- R5: Lengthening places the low P bytes of `cfg_pfx` directly above the existing source bytes, and the new source length is the old length plus P.
- R6: When lengthening would exceed 16 bytes, the result is clamped to 16 bytes (code 0). Only the low 16 bytes are kept.
- R7: Shortening applies when P is below the destination length and the top P destination bytes equal the low P bytes of `cfg_pfx`. Those bytes are removed, and the new length is the old length minus P.
- R8: When shortening finds a mismatch, or P is not below the destination length, `o_err` is raised and both addresses and codes leave unmodified.
- R9: P is `cfg_pfx_len`, limited to 16. A value of 0 makes both edits leave the address as it was.
- R10: The output hop limit is the input minus one, and it stays 0 when the input is 0. `o_drop` is raised when the input hop limit is 0 or 1.
- R11: `o_hdr_len` is 6 plus both output address byte counts, rounded up to a multiple of 4 (8 to 40).
- R12: Traffic class, flow label and next-header pass through unchanged.
- R13: Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_vld | input | 1 | Input fields valid |
| i_act | input | 2 | Edit action from lookup |
| i_tc | input | 8 | Traffic class |
| i_hl | input | 4 | Hop limit |
| i_flow | input | 20 | Flow label |
| i_nh | input | 8 | Next header |
| i_sal | input | 4 | Source length code |
| i_dal | input | 4 | Destination length code |
| i_sa | input | 128 | Source address, right-aligned |
| i_da | input | 128 | Destination address, right-aligned |
| cfg_pfx | input | 128 | This level's prefix, right-aligned |
| cfg_pfx_len | input | 5 | Prefix byte count |
| o_vld | output | 1 | Output valid |
| o_tc | output | 8 | Traffic class |
| o_hl | output | 4 | Decremented hop limit |
| o_flow | output | 20 | Flow label |
| o_nh | output | 8 | Next header |
| o_sal | output | 4 | New source length code |
| o_dal | output | 4 | New destination length code |
| o_sa | output | 128 | Rewritten source address |
| o_da | output | 128 | Rewritten destination address |
| o_hdr_len | output | 6 | Padded header length in bytes |
| o_drop | output | 1 | Hop limit expired |
| o_err | output | 1 | Prefix mismatch on shortening |

## Verification
The assertions watch, on every cycle, the following properties:
- the one-cycle valid timing;
- that equal-length packets leave with their codes intact;
- that a failed prefix comparison leaves both codes unchanged and raises the error;
- that the header length is always 4-byte aligned and within range;
- the expiry flagging;
- the pass-through fields.

Only the bench scenarios can show the actual byte placement: the prefix above the source, the clamp to 16 bytes, the exact bytes removed on a match, and the zeroing above each length. The bench compares these against a byte-by-byte model, using random prefixes that are sometimes planted into the destination.

// File: rtl/hgw_pkg.sv
package hgw_pkg;
  localparam int ADDR_BYTES = 16;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int LEN_W      = $clog2(ADDR_BYTES + 1);
  localparam int CODE_W     = 4;
  localparam int HDR_W      = 6;
  localparam int HDR_FIXED  = 6;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LEN_W-1:0]  len_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [HDR_W-1:0]  hdr_t;

  typedef enum logic [1:0] {
    ACT_PASS    = 2'd0,
    ACT_GROW_SA = 2'd1,
    ACT_TRIM_DA = 2'd2,
    ACT_RSVD    = 2'd3
  } act_e;

  // length code -> byte count (0 means full width)
  function automatic len_t f_len(input code_t c);
    return (c == '0) ? len_t'(ADDR_BYTES) : len_t'(c);
  endfunction

  // byte count -> length code
  function automatic code_t f_code(input len_t n);
    return (n >= len_t'(ADDR_BYTES)) ? '0 : code_t'(n);
  endfunction

  // mask keeping the low n bytes
  function automatic addr_t f_mask(input len_t n);
    addr_t m;
    for (int i = 0; i < ADDR_BYTES; i++)
      m[8*i +: 8] = (len_t'(i) < n) ? 8'hFF : 8'h00;
    return m;
  endfunction

  // fixed part plus both addresses, rounded up to 4 bytes
  function automatic hdr_t f_pad(input len_t sb, input len_t db);
    hdr_t t;
    t = hdr_t'(HDR_FIXED) + hdr_t'(sb) + hdr_t'(db) + hdr_t'(3);
    return t & ~hdr_t'(3);
  endfunction
endpackage

// File: rtl/hgw_grow.sv
module hgw_grow
  import hgw_pkg::*;
(
  input  addr_t sa_i,
  input  len_t  sl_i,
  input  len_t  pl_i,
  input  addr_t pfx_i,
  output addr_t sa_o,
  output len_t  sl_o
);
  logic [LEN_W:0] sum;
  addr_t          lifted;

  always_comb begin
    sum    = {1'b0, sl_i} + {1'b0, pl_i};
    sl_o   = (sum > (LEN_W+1)'(ADDR_BYTES)) ? len_t'(ADDR_BYTES) : sum[LEN_W-1:0];
    lifted = (pfx_i & f_mask(pl_i)) << {sl_i, 3'b000};
    sa_o   = (lifted | (sa_i & f_mask(sl_i))) & f_mask(sl_o);
  end
endmodule

// File: rtl/hgw_trim.sv
module hgw_trim
  import hgw_pkg::*;
(
  input  addr_t da_i,
  input  len_t  dl_i,
  input  len_t  pl_i,
  input  addr_t pfx_i,
  output addr_t da_o,
  output len_t  dl_o,
  output logic  ok_o
);
  len_t  keep;
  addr_t upper;
  logic  room;

  always_comb begin
    room  = pl_i < dl_i;
    keep  = dl_i - pl_i;
    upper = (da_i >> {keep, 3'b000}) & f_mask(pl_i);
    ok_o  = room && (upper == (pfx_i & f_mask(pl_i)));
    dl_o  = ok_o ? keep : dl_i;
    da_o  = da_i & f_mask(dl_o);
  end
endmodule

// File: rtl/hgw_hop.sv
module hgw_hop
  import hgw_pkg::*;
(
  input  logic [3:0] hl_i,
  output logic [3:0] hl_o,
  output logic       expire_o
);
  always_comb begin
    expire_o = hl_i <= 4'd1;
    hl_o     = (hl_i == 4'd0) ? 4'd0 : hl_i - 4'd1;
  end
endmodule

// File: rtl/hier_gw_rewriter.sv
module hier_gw_rewriter
  import hgw_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         i_vld,
  input  logic [1:0]   i_act,
  input  logic [7:0]   i_tc,
  input  logic [3:0]   i_hl,
  input  logic [19:0]  i_flow,
  input  logic [7:0]   i_nh,
  input  logic [3:0]   i_sal,
  input  logic [3:0]   i_dal,
  input  logic [127:0] i_sa,
  input  logic [127:0] i_da,
  input  logic [127:0] cfg_pfx,
  input  logic [4:0]   cfg_pfx_len,
  output logic         o_vld,
  output logic [7:0]   o_tc,
  output logic [3:0]   o_hl,
  output logic [19:0]  o_flow,
  output logic [7:0]   o_nh,
  output logic [3:0]   o_sal,
  output logic [3:0]   o_dal,
  output logic [127:0] o_sa,
  output logic [127:0] o_da,
  output logic [5:0]   o_hdr_len,
  output logic         o_drop,
  output logic         o_err
);
  len_t  sl, dl, pl;
  len_t  grow_sl, trim_dl, sl_n, dl_n;
  addr_t grow_sa, trim_da, sa_n, da_n;
  logic  trim_ok, hop_expire;
  logic [3:0] hl_n;

  // named events for the checks
  logic edit_same, grow_fire, trim_fire, trim_fault;

  always_comb begin
    sl = f_len(i_sal);
    dl = f_len(i_dal);
    pl = (cfg_pfx_len > len_t'(ADDR_BYTES)) ? len_t'(ADDR_BYTES) : cfg_pfx_len;
  end

  hgw_grow u_grow (
    .sa_i(i_sa), .sl_i(sl), .pl_i(pl), .pfx_i(cfg_pfx),
    .sa_o(grow_sa), .sl_o(grow_sl)
  );

  hgw_trim u_trim (
    .da_i(i_da), .dl_i(dl), .pl_i(pl), .pfx_i(cfg_pfx),
    .da_o(trim_da), .dl_o(trim_dl), .ok_o(trim_ok)
  );

  hgw_hop u_hop (
    .hl_i(i_hl), .hl_o(hl_n), .expire_o(hop_expire)
  );

  always_comb begin
    edit_same  = (i_sal == i_dal);
    grow_fire  = (act_e'(i_act) == ACT_GROW_SA) && !edit_same;
    trim_fire  = (act_e'(i_act) == ACT_TRIM_DA) && !edit_same;
    trim_fault = trim_fire && !trim_ok;
    sa_n = grow_fire ? grow_sa : (i_sa & f_mask(sl));
    sl_n = grow_fire ? grow_sl : sl;
    da_n = (trim_fire && trim_ok) ? trim_da : (i_da & f_mask(dl));
    dl_n = (trim_fire && trim_ok) ? trim_dl : dl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_vld <= 1'b0; o_tc <= '0; o_hl <= '0; o_flow <= '0; o_nh <= '0;
      o_sal <= '0; o_dal <= '0; o_sa <= '0; o_da <= '0;
      o_hdr_len <= '0; o_drop <= 1'b0; o_err <= 1'b0;
    end else begin
      o_vld     <= i_vld;
      o_tc      <= i_tc;
      o_hl      <= hl_n;
      o_flow    <= i_flow;
      o_nh      <= i_nh;
      o_sal     <= f_code(sl_n);
      o_dal     <= f_code(dl_n);
      o_sa      <= sa_n;
      o_da      <= da_n;
      o_hdr_len <= f_pad(sl_n, dl_n);
      o_drop    <= i_vld && hop_expire;
      o_err     <= i_vld && trim_fault;
    end
  end

  AST_VLD_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    i_vld |=> o_vld); // R1
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !i_vld |=> (!o_vld && !o_err && !o_drop)); // R1
  AST_SAME_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (i_vld && edit_same) |=> (o_sal == $past(i_sal) && o_dal == $past(i_dal) && !o_err)); // R3
  AST_FAULT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (i_vld && trim_fault) |=> (o_err && o_sal == $past(i_sal) && o_dal == $past(i_dal))); // R8
  AST_HDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld |-> (o_hdr_len[1:0] == 2'b00 && o_hdr_len >= 6'd8 && o_hdr_len <= 6'd40)); // R11
  AST_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (i_vld && i_hl <= 4'd1) |=> (o_drop && o_hl == 4'd0)); // R10
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    i_vld |=> (o_tc == $past(i_tc) && o_flow == $past(i_flow) && o_nh == $past(i_nh))); // R12
endmodule

// File: tb/hier_gw_rewriter_bench.sv
module hier_gw_rewriter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_vld = 1'b0;
  logic [1:0] i_act = '0;
  logic [7:0] i_tc = '0;
  logic [3:0] i_hl = '0;
  logic [19:0] i_flow = '0;
  logic [7:0] i_nh = '0;
  logic [3:0] i_sal = '0, i_dal = '0;
  logic [127:0] i_sa = '0, i_da = '0, cfg_pfx = '0;
  logic [4:0] cfg_pfx_len = '0;
  logic o_vld, o_drop, o_err;
  logic [7:0] o_tc, o_nh;
  logic [3:0] o_hl, o_sal, o_dal;
  logic [19:0] o_flow;
  logic [127:0] o_sa, o_da;
  logic [5:0] o_hdr_len;

  int total = 0, bad = 0;
  logic [127:0] e_sa, e_da;
  logic [3:0] e_sal, e_dal, e_hl;
  logic [5:0] e_hdr;
  logic e_drop, e_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  hier_gw_rewriter u_hier_gw_rewriter (
    .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_act(i_act), .i_tc(i_tc),
    .i_hl(i_hl), .i_flow(i_flow), .i_nh(i_nh), .i_sal(i_sal), .i_dal(i_dal),
    .i_sa(i_sa), .i_da(i_da), .cfg_pfx(cfg_pfx), .cfg_pfx_len(cfg_pfx_len),
    .o_vld(o_vld), .o_tc(o_tc), .o_hl(o_hl), .o_flow(o_flow), .o_nh(o_nh),
    .o_sal(o_sal), .o_dal(o_dal), .o_sa(o_sa), .o_da(o_da),
    .o_hdr_len(o_hdr_len), .o_drop(o_drop), .o_err(o_err)
  );

  // byte-level reference model
  task automatic model();
    logic [7:0] sb[16];
    logic [7:0] db[16];
    int ns, nd, p, t;
    bit same, match;
    ns = (i_sal == 0) ? 16 : int'(i_sal);
    nd = (i_dal == 0) ? 16 : int'(i_dal);
    p  = (cfg_pfx_len > 16) ? 16 : int'(cfg_pfx_len);
    for (int k = 0; k < 16; k++) begin
      sb[k] = (k < ns) ? i_sa[8*k +: 8] : 8'h00;
      db[k] = (k < nd) ? i_da[8*k +: 8] : 8'h00;
    end
    same = (ns == nd);
    e_err = 1'b0;
    if (i_act == 2'd1 && !same) begin
      for (int k = 0; k < p; k++)
        if (ns + k < 16) sb[ns + k] = cfg_pfx[8*k +: 8];
      ns = (ns + p > 16) ? 16 : ns + p;
    end else if (i_act == 2'd2 && !same) begin
      match = (p < nd);
      if (match)
        for (int k = 0; k < p; k++)
          if (db[nd - p + k] != cfg_pfx[8*k +: 8]) match = 1'b0;
      if (match) begin
        for (int k = 0; k < p; k++) db[nd - p + k] = 8'h00;
        nd = nd - p;
      end else e_err = i_vld;
    end
    for (int k = 0; k < 16; k++) begin
      e_sa[8*k +: 8] = sb[k];
      e_da[8*k +: 8] = db[k];
    end
    e_sal = (ns == 16) ? 4'd0 : 4'(ns);
    e_dal = (nd == 16) ? 4'd0 : 4'(nd);
    t = 6 + ns + nd;
    while (t % 4 != 0) t++;
    e_hdr  = 6'(t);
    e_hl   = (i_hl == 0) ? 4'd0 : i_hl - 4'd1;
    e_drop = i_vld && (i_hl < 2);
  endtask

  task automatic run(input string tag);
    logic [7:0] x_tc, x_nh;
    logic [19:0] x_flow;
    logic x_vld;
    model();
    x_tc = i_tc; x_nh = i_nh; x_flow = i_flow; x_vld = i_vld;
    @(posedge clk);
    @(negedge clk);
    total++;
    if (o_vld !== x_vld || o_sa !== e_sa || o_da !== e_da || o_sal !== e_sal ||
        o_dal !== e_dal || o_hl !== e_hl || o_hdr_len !== e_hdr ||
        o_drop !== e_drop || o_err !== e_err || o_tc !== x_tc ||
        o_nh !== x_nh || o_flow !== x_flow) begin
      bad++;
      $display("FAIL %s: got vld=%b sal=%h dal=%h hl=%h hdr=%0d drop=%b err=%b sa=%h da=%h | exp vld=%b sal=%h dal=%h hl=%h hdr=%0d drop=%b err=%b sa=%h da=%h",
        tag, o_vld, o_sal, o_dal, o_hl, o_hdr_len, o_drop, o_err, o_sa, o_da,
        x_vld, e_sal, e_dal, e_hl, e_hdr, e_drop, e_err, e_sa, e_da);
    end
  endtask

  task automatic setv(input logic [1:0] act, input logic [3:0] sal, input logic [3:0] dal,
                      input logic [127:0] sa, input logic [127:0] da,
                      input logic [127:0] pfx, input logic [4:0] pl, input logic [3:0] hl);
    i_vld = 1'b1; i_act = act; i_sal = sal; i_dal = dal; i_sa = sa; i_da = da;
    cfg_pfx = pfx; cfg_pfx_len = pl; i_hl = hl;
    i_tc = 8'($urandom); i_nh = 8'($urandom); i_flow = 20'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unused_seed;
    int p, n;
    unused_seed = $urandom(32'h00C0FFEE);
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (o_vld !== 1'b0 || o_sa !== '0 || o_hdr_len !== '0 || o_err !== 1'b0) begin
      bad++;
      $display("FAIL R13: got vld=%b sa=%h hdr=%0d exp all zero", o_vld, o_sa, o_hdr_len);
    end
    rst_n = 1'b1;

    // R3 equal short lengths with a grow request: untouched
    setv(2'd1, 4'd1, 4'd1, 128'hAB, 128'hCD, 128'h112233, 5'd3, 4'd5); run("R3");
    // R5 grow source from 1 byte with a 3-byte prefix
    setv(2'd1, 4'd1, 4'd4, 128'h5A, 128'h0A0B0C0D, 128'hC1C2C3, 5'd3, 4'd7); run("R5");
    // R6 clamp: 14 + 4 bytes -> 16 bytes, code 0
    setv(2'd1, 4'd14, 4'd2, {16{8'h77}}, 128'h1234, 128'hF1F2F3F4, 5'd4, 4'd9); run("R6");
    // R7 trim matching prefix: 4-byte DA with top 3 = prefix
    setv(2'd2, 4'd1, 4'd4, 128'h09, 128'hC1C2C3_44, 128'hC1C2C3, 5'd3, 4'd4); run("R7");
    // R8 trim mismatch
    setv(2'd2, 4'd1, 4'd4, 128'h09, 128'hC1FFC3_44, 128'hC1C2C3, 5'd3, 4'd4); run("R8");
    // R8 prefix not shorter than DA
    setv(2'd2, 4'd1, 4'd3, 128'h09, 128'hC1C2C3, 128'hC1C2C3, 5'd3, 4'd4); run("R8");
    // R4 reserved action acts as pass; stale bytes above length zeroed (R2)
    setv(2'd3, 4'd2, 4'd0, {16{8'hEE}}, {16{8'h99}}, 128'h1, 5'd1, 4'd3); run("R4");
    // R9 oversized prefix length limited to 16
    setv(2'd1, 4'd2, 4'd5, 128'hBEEF, 128'h5, {16{8'h3C}}, 5'd20, 4'd6); run("R9");
    // R9 zero prefix length: grow leaves source as is
    setv(2'd1, 4'd2, 4'd5, 128'hBEEF, 128'h5, {16{8'h3C}}, 5'd0, 4'd6); run("R9");
    // R10 hop limit 1 and 0
    setv(2'd0, 4'd1, 4'd1, 128'h1, 128'h2, 128'h0, 5'd1, 4'd1); run("R10");
    setv(2'd0, 4'd1, 4'd1, 128'h1, 128'h2, 128'h0, 5'd1, 4'd0); run("R10");
    // R11 both full width: 40 bytes
    setv(2'd0, 4'd0, 4'd0, {4{32'h0BADF00D}}, {4{32'h12345678}}, 128'h0, 5'd0, 4'd15); run("R11");
    // R1 idle cycle: valid low, flags low
    i_vld = 1'b0; i_hl = 4'd0; i_act = 2'd2; run("R1");

    // R2 R12 random mix, prefix sometimes planted so trims match
    for (int v = 0; v < 400; v++) begin
      setv(2'($urandom), 4'($urandom), 4'($urandom), {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
           5'($urandom_range(0, 20)), 4'($urandom));
      i_vld = ($urandom_range(0, 7) != 0);
      p = (cfg_pfx_len > 16) ? 16 : int'(cfg_pfx_len);
      n = (i_dal == 0) ? 16 : int'(i_dal);
      if (i_act == 2'd2 && p < n && $urandom_range(0, 1) == 1)
        for (int k = 0; k < p; k++) i_da[8*(n - p + k) +: 8] = cfg_pfx[8*k +: 8];
      run("R2/R12 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule